// File: doc/BRIEF.md
# Framebuffer Refresh Cycle-Stealing DMA

This block keeps a monochrome display fed from a framebuffer held in system memory. The framebuffer is a grid of rows of bytes, 64 rows of 16 bytes by default. The block does not copy it in one long transfer. It borrows the memory bus from the host CPU in short bursts of a few bytes, and a fixed pacing interval separates one burst from the next. That interval is derived from the clock rate, the refresh rate and the burst size, so the last burst of a frame lands just as the next refresh period begins.

For each burst the block raises a bus request and holds it until the CPU grants the bus. It then reads one byte per granted cycle and keeps the request for one more cycle after the last byte. With an immediate grant, every burst occupies the bus for its data cycles plus two hand-over cycles. Each byte read comes out on the display-side stream one cycle later. A marker flags the first byte of every row and another flags the first byte of every frame. Clearing the enable input stops all new bursts, which hands those cycles back to the CPU.

Top module: `fbdma_refresh`

## Requirements
- R1: While rst_n is low, bus_req, mem_rd, pix_valid, pix_row_start and pix_frame_start are all 0.
- R2: mem_rd is 1 only in cycles where both bus_req and bus_gnt are 1. While bus_req is 1 and the grant is withheld, bus_req stays 1 and mem_rd stays 0.
- R3: Each burst reads exactly BURST_LEN bytes in consecutive cycles. Bytes are read in ascending address order: frame base plus row*ROW_BYTES plus column.
- R4: bus_req stays 1 for exactly one cycle after the last read of a burst and then drops. With an immediate grant, a frame holds the bus for (FRAME_BYTES/BURST_LEN)*(BURST_LEN+2) cycles.
- R5: With an immediate grant, bus_req rises every INTERVAL = CLK_HZ/(REFRESH_HZ*FRAME_BYTES/BURST_LEN) clocks, and frame starts are INTERVAL*FRAME_BYTES/BURST_LEN clocks apart.
- R6: pix_valid is 1 in the cycle after each read, and pix_data then equals the byte the memory returned for that read.
- R7: pix_row_start is 1 together with pix_valid exactly when the byte is the first byte of a row, that is, when the byte index within the frame is a multiple of ROW_BYTES.
- R8: After the last byte of a frame the address wraps to the base. pix_frame_start is 1 only on the frame's first byte (index 0), and always together with pix_row_start.
- R9: fb_base is sampled only while the byte index is 0 and no read is in progress. A change in the middle of a frame takes effect at the next frame.
- R10: While enable is 0, no new burst is requested. A burst already in progress finishes, and the next enable restarts at the first byte of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Refresh on; 0 stops new bursts |
| fb_base | input | ADDR_W | Framebuffer start address |
| bus_req | output | 1 | Bus request to the host |
| bus_gnt | input | 1 | Bus grant from the host |
| mem_addr | output | ADDR_W | Read address, valid while mem_rd is 1 |
| mem_rd | output | 1 | Read strobe, one byte per cycle |
| mem_rdata | input | 8 | Read data, returned one cycle after mem_rd |
| pix_data | output | 8 | Display byte |
| pix_valid | output | 1 | pix_data is valid |
| pix_row_start | output | 1 | First byte of a row |
| pix_frame_start | output | 1 | First byte of a frame |

## Verification
The bench uses a 16-byte frame of four rows, with 2-byte bursts and a 16-clock interval. The memory model returns a byte computed from each address, so any address or ordering slip shows up in the data. With an immediate grant, the bench measures request spacing, frame period and bus occupancy per frame, which separates pacing faults from hand-over overhead faults. Moving the base address mid-frame tests when the base is sampled. Withholding the grant for several cycles confirms that no address is driven early and that the byte order survives stretched bursts. Dropping enable checks that the bus goes quiet and that refresh restarts at the frame start.

// File: rtl/fbdma_pkg.sv
// Shared definitions for the framebuffer refresh DMA.
// Assumes a byte-wide memory read path.
package fbdma_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // bus released, waiting for a pacing tick
        ST_WAIT = 2'd1,   // request raised, waiting for grant
        ST_XFER = 2'd2,   // one byte read per cycle
        ST_REL  = 2'd3    // hand-over cycle after the last byte
    } burst_state_t;
endpackage

// File: rtl/fbdma_pacer.sv
// Burst pacing timer: emits a one-cycle tick every INTERVAL clocks while
// enabled, with the first tick in the first enabled cycle.
// Assumes INTERVAL >= 1.
module fbdma_pacer #(
    parameter int INTERVAL = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic tick
);
    localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

    logic [CNT_W-1:0] cnt_q;

    // Free-running modulo-INTERVAL counter, held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // Tick when the counter sits at its origin.
    assign tick = enable && (cnt_q == '0);
endmodule

// File: rtl/fbdma_addr_gen.sv
// Framebuffer address generator: keeps row and column counters, adds them
// to the latched base, and flags the first byte of a row and of a frame.
// Assumes advance is asserted once per byte read.
module fbdma_addr_gen #(
    parameter int ADDR_W    = 16,
    parameter int ROWS      = 64,
    parameter int ROW_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              restart,
    input  logic [ADDR_W-1:0] fb_base,
    output logic [ADDR_W-1:0] addr,
    output logic              row_first,
    output logic              frame_first
);
    localparam int COL_W = (ROW_BYTES > 1) ? $clog2(ROW_BYTES) : 1;
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(ROW_BYTES - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    logic [COL_W-1:0]  col_q;
    logic [ROW_W-1:0]  row_q;
    logic [ADDR_W-1:0] base_q;
    logic              at_origin;

    assign at_origin = (col_q == '0) && (row_q == '0);

    // Column and row counters, wrapping at row end and frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            col_q <= '0;
            row_q <= '0;
        end else if (advance) begin
            if (col_q == COL_LAST) begin
                col_q <= '0;
                row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
            end else begin
                col_q <= col_q + 1'b1;
            end
        end
    end

    // Base follows fb_base only between frames.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (at_origin && !advance)
            base_q <= fb_base;
    end

    assign addr = base_q
                + ADDR_W'(row_q) * ADDR_W'(ROW_BYTES)
                + ADDR_W'(col_q);
    assign row_first   = (col_q == '0);
    assign frame_first = at_origin;
endmodule

// File: rtl/fbdma_burst_fsm.sv
// Burst sequencer: on a pacing tick it requests the bus, waits for grant,
// reads BURST_LEN bytes back to back, and then holds the request for one
// release cycle. A tick that arrives mid-burst is kept pending, one deep.
// Assumes the host keeps bus_gnt high once given while bus_req is high.
module fbdma_burst_fsm
    import fbdma_pkg::*;
#(
    parameter int BURST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic bus_gnt,
    output logic bus_req,
    output logic mem_rd,
    output logic idle
);
    localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BURST_LEN - 1);

    burst_state_t     state_q, state_d;
    logic [BEAT_W-1:0] beat_q;
    logic              pend_q;
    logic              start;

    assign start = enable && (tick || pend_q);

    // Next-state selection for the burst sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)                state_d = ST_WAIT;
            ST_WAIT: if (bus_gnt)              state_d = ST_XFER;
            ST_XFER: if (beat_q == BEAT_LAST)  state_d = ST_REL;
            ST_REL:                            state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Beat counter within a burst.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_XFER)
            beat_q <= '0;
        else
            beat_q <= beat_q + 1'b1;
    end

    // Holds a tick that arrived while the bus was busy.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            pend_q <= 1'b0;
        else if (state_q != ST_IDLE && tick)
            pend_q <= 1'b1;
        else if (state_q == ST_IDLE)
            pend_q <= 1'b0;
    end

    assign bus_req = (state_q != ST_IDLE);
    assign mem_rd  = (state_q == ST_XFER);
    assign idle    = (state_q == ST_IDLE);
endmodule

// File: rtl/fbdma_refresh.sv
// Framebuffer refresh DMA top: paces bursts, sequences the bus hand-over,
// generates addresses, and registers the display stream markers one cycle
// after each read, in step with the synchronous memory's data.
// Assumes INTERVAL >= BURST_LEN + 2 and FRAME_BYTES divisible by BURST_LEN.
module fbdma_refresh
    import fbdma_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int ROWS       = 64,
    parameter int ROW_BYTES  = 16,
    parameter int BURST_LEN  = 4,
    parameter int CLK_HZ     = 5_120_000,
    parameter int REFRESH_HZ = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] fb_base,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] pix_data,
    output logic              pix_valid,
    output logic              pix_row_start,
    output logic              pix_frame_start
);
    localparam int FRAME_BYTES = ROWS * ROW_BYTES;
    localparam int BURSTS      = FRAME_BYTES / BURST_LEN;
    localparam int INTERVAL    = CLK_HZ / (REFRESH_HZ * BURSTS);

    logic tick, idle, row_first, frame_first;

    fbdma_pacer #(.INTERVAL(INTERVAL)) u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .tick   (tick)
    );

    fbdma_burst_fsm #(.BURST_LEN(BURST_LEN)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .tick    (tick),
        .bus_gnt (bus_gnt),
        .bus_req (bus_req),
        .mem_rd  (mem_rd),
        .idle    (idle)
    );

    fbdma_addr_gen #(
        .ADDR_W    (ADDR_W),
        .ROWS      (ROWS),
        .ROW_BYTES (ROW_BYTES)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .advance     (mem_rd),
        .restart     (!enable && idle),
        .fb_base     (fb_base),
        .addr        (mem_addr),
        .row_first   (row_first),
        .frame_first (frame_first)
    );

    // Stream flags delayed to match the memory read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid       <= 1'b0;
            pix_row_start   <= 1'b0;
            pix_frame_start <= 1'b0;
        end else begin
            pix_valid       <= mem_rd;
            pix_row_start   <= mem_rd && row_first;
            pix_frame_start <= mem_rd && frame_first;
        end
    end

    assign pix_data = pix_valid ? mem_rdata : '0;
endmodule

// File: rtl/fbdma_refresh_chk.sv
// Protocol checker for fbdma_refresh, attached by bind.
// Assumes the bound instance's port names.
module fbdma_refresh_chk #(
    parameter int BURST_LEN = 4
) (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic bus_req,
    input logic bus_gnt,
    input logic mem_rd,
    input logic pix_valid,
    input logic pix_row_start,
    input logic pix_frame_start
);
    logic [15:0] run_q;

    // Length of the current unbroken run of read cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !mem_rd)
            run_q <= '0;
        else
            run_q <= run_q + 1'b1;
    end

    AST_RD_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (bus_req && bus_gnt)); // R2
    AST_NO_EARLY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> !mem_rd); // R2
    AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (run_q < 16'(BURST_LEN))); // R3
    AST_RELEASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd) |-> bus_req); // R4
    AST_RELEASE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd) |=> !bus_req); // R4
    AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(mem_rd)); // R6
    AST_FRAME_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        pix_frame_start |-> (pix_valid && pix_row_start)); // R8
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !bus_req) |=> !bus_req); // R10
endmodule

bind fbdma_refresh fbdma_refresh_chk #(.BURST_LEN(BURST_LEN)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .enable          (enable),
    .bus_req         (bus_req),
    .bus_gnt         (bus_gnt),
    .mem_rd          (mem_rd),
    .pix_valid       (pix_valid),
    .pix_row_start   (pix_row_start),
    .pix_frame_start (pix_frame_start)
);

// File: tb/fbdma_refresh_tb.sv
// Bench for fbdma_refresh on a 4x4-byte frame, 2-byte bursts, 16-clock interval.
module fbdma_refresh_tb;
    localparam int AW = 16, RW = 4, RB = 4, BL = 2;
    localparam int CHZ = 128_000, RHZ = 1000;
    localparam int FB = RW * RB, NB = FB / BL;
    localparam int INTV = CHZ / (RHZ * NB);
    localparam int PERIOD = INTV * NB;
    localparam int HELD = NB * (BL + 2);

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, gnt_allow = 1'b1;
    logic [AW-1:0] fb_base = 16'h1200;
    logic bus_req, bus_gnt, mem_rd, pix_valid, pix_row_start, pix_frame_start;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_rdata = 8'h00, pix_data;

    int n_cmp = 0, n_bad = 0;
    bit done = 0, mon_on = 0, steady = 0, moved = 0;
    int k = 0, cyc = 0, held = 0, last_fs = 0, last_rise = 0;
    bit fs_ok = 0, rise_ok = 0, req_q = 0;
    logic [AW-1:0] exp_base = '0;

    always #2.5 clk = ~clk;

    assign bus_gnt = bus_req && gnt_allow;

    fbdma_refresh #(.ADDR_W(AW), .ROWS(RW), .ROW_BYTES(RB), .BURST_LEN(BL),
                    .CLK_HZ(CHZ), .REFRESH_HZ(RHZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fb_base(fb_base),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_rdata(mem_rdata), .pix_data(pix_data),
        .pix_valid(pix_valid), .pix_row_start(pix_row_start),
        .pix_frame_start(pix_frame_start));

    function automatic logic [7:0] model(input logic [AW-1:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Synchronous memory model: data appears the cycle after a read.
    always @(posedge clk) if (mem_rd) mem_rdata <= model(mem_addr);

    // Stream and bus monitor, sampled away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            if (bus_req && bus_gnt) held++;
            if (bus_req && !req_q) begin
                if (steady && rise_ok) chk(cyc - last_rise == INTV, "R5 req spacing", cyc - last_rise, INTV);
                last_rise = cyc;
                rise_ok = steady;
            end
            req_q = bus_req;
            if (pix_valid) begin
                if (k == 0) exp_base = fb_base;
                chk(pix_data == model(exp_base + AW'(k)), moved ? "R9 base data" : "R3/R6 data",
                    pix_data, model(exp_base + AW'(k)));
                chk(pix_row_start == (k % RB == 0), "R7 row mark", pix_row_start, k % RB == 0);
                chk(pix_frame_start == (k == 0), "R8 frame mark", pix_frame_start, k == 0);
                if (k == 0) begin
                    if (steady && fs_ok) begin
                        chk(held == HELD, "R4 bus cycles/frame", held, HELD);
                        chk(cyc - last_fs == PERIOD, "R5 frame period", cyc - last_fs, PERIOD);
                    end
                    held = 0;
                    last_fs = cyc;
                    fs_ok = steady;
                end
                k = (k + 1) % FB;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int quiet_bad;
        // R1: reset state.
        repeat (3) @(negedge clk);
        chk(!bus_req && !mem_rd && !pix_valid && !pix_row_start && !pix_frame_start,
            "R1 reset outputs", {bus_req, mem_rd, pix_valid}, 0);
        rst_n = 1'b1;
        mon_on = 1;
        // R10: disabled after reset stays off the bus.
        quiet_bad = 0;
        repeat (20) begin @(negedge clk); if (bus_req) quiet_bad++; end
        chk(quiet_bad == 0, "R10 idle while disabled", quiet_bad, 0);

        // Immediate grant, steady pacing, three frames.
        steady = 1;
        enable = 1'b1;
        repeat (3 * PERIOD + 8) @(negedge clk);

        // R9: move the base mid-frame; new base applies from next frame.
        do @(negedge clk); while (!pix_frame_start);
        repeat (PERIOD / 2) @(negedge clk);
        fb_base = 16'h3470;
        moved = 1;
        repeat (2 * PERIOD + 8) @(negedge clk);

        // R2: withheld grant, request held, no address driven.
        steady = 0;
        fs_ok = 0;
        rise_ok = 0;
        for (int i = 0; i < 6; i++) begin
            while (bus_req) @(negedge clk);
            gnt_allow = 1'b0;
            do @(negedge clk); while (!bus_req);
            repeat (5) begin
                @(negedge clk);
                chk(bus_req && !mem_rd, "R2 wait for grant", {bus_req, mem_rd}, 2);
            end
            gnt_allow = 1'b1;
            do @(negedge clk); while (bus_req);
        end

        // R10: disable stops bursts; re-enable restarts at the frame start.
        enable = 1'b0;
        repeat (20) @(negedge clk);
        quiet_bad = 0;
        repeat (100) begin @(negedge clk); if (bus_req || pix_valid) quiet_bad++; end
        chk(quiet_bad == 0, "R10 quiet after disable", quiet_bad, 0);
        k = 0;
        enable = 1'b1;
        do @(negedge clk); while (!pix_valid);
        chk(pix_frame_start == 1'b1, "R10 restart at frame", pix_frame_start, 1);
        repeat (PERIOD + 8) @(negedge clk);

        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule